// File: doc/BRIEF.md
# Dual-Prescaler Clock Generator Controller

This block controls clock generation for a small microcontroller. Every derived clock is modelled as a one-cycle enable strobe in a single fast clock domain, so the design has no clock muxes and no combinational gating on a clock net. The oscillators appear as tick inputs, each high for one fast cycle per edge of that oscillator. A source selector feeds either the internal RC oscillator ticks or the external clock ticks into an 8-bit high prescaler. A 32 kHz reference comes from the crystal ticks once the crystal has been enabled and has finished a programmable startup count. Until then, the reference falls back to one chosen tap of the high prescaler. The reference drives a 15-bit low prescaler whose last tap runs at 1 Hz.

The CPU clock enable follows either the fast source or the reference, and it is held low while the halt input is set. Two output strobes can be routed to pins: one carrying half the reference rate, and one carrying the CPU clock. Software reaches the block through a byte-wide register port with a 2-bit address and separate write and read strobes. Read data is registered. There are two reset classes. The cold reset clears everything. The sleep reset leaves the external-clock enable and the RC-bias enable untouched.

There is no data stream in this block, so every pin is a plain control or status signal and no valid/ready handshake is used.

Top module: `clkgen_ctrl`

## Requirements
- R1: After a cold reset, a read of address 0 (control) returns 0x19 and reads of addresses 1, 2 and 3 return 0x00.
- R2: The high prescaler input is `ext_tick` when control bit 5 (external enable) is 1. Otherwise it is `rc_tick` gated by control bit 0 (RC enable). Tap k of `hp_stb` fires on every 2^(k+1)-th input tick counted from reset.
- R3: Control bit 3 is read-only. It reads 1 while control bit 1 (crystal enable) is 0, and after that bit is set it keeps reading 1 for XTAL_START (default 4) `xtal_tick` pulses. While it reads 1, `ref_stb` equals `hp_stb[REF_TAP]` (default tap 7). Otherwise `ref_stb` equals `xtal_tick`.
- R4: Tap k of the 15-bit low prescaler `lp_stb` fires on every 2^(k+1)-th `ref_stb`, so tap 14 fires once per 32768 reference pulses.
- R5: Writing 1 to bit 0 at address 2 returns the low prescaler count to zero. Writing 0 there has no effect, and a read of address 2 always returns 0x00.
- R6: With control bit 7 = 0, `cpu_clk_en` follows the high prescaler input of R2. With bit 7 = 1, it follows `ref_stb`.
- R7: While `halt` is 1, `cpu_clk_en` stays 0.
- R8: Miscellaneous register (address 1): when bit 1 is set, `pin16k_stb` follows `lp_stb[0]`; when bit 0 is set, `pincpu_stb` follows `cpu_clk_en`. When a bit is clear, its output stays 0.
- R9: A sleep reset (`sleep_rst_n` low with `cold_rst_n` high) returns control bits 7, 1 and 0 to 0, 0 and 1 and clears the miscellaneous register, while control bits 5 and 4 keep their values. A cold reset returns bit 5 to 0 and bit 4 to 1.
- R10: Control bits 6 and 2 read as 0 and address 3 reads as 0x00. `reg_rdata` loads on the clock edge where `reg_rd` is sampled high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock for all logic |
| cold_rst_n | input | 1 | Cold reset, synchronous, active low |
| sleep_rst_n | input | 1 | Sleep reset, synchronous, active low |
| rc_tick | input | 1 | One-cycle pulse per RC oscillator edge |
| ext_tick | input | 1 | One-cycle pulse per external clock edge |
| xtal_tick | input | 1 | One-cycle pulse per crystal (32 kHz) edge |
| halt | input | 1 | Halt mode, stops the CPU clock enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| rc_en_o | output | 1 | RC oscillator enable |
| rc_bias_o | output | 1 | RC bias enable |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| ext_en_o | output | 1 | External clock enable |
| hp_stb | output | HP_W | High prescaler tap strobes |
| ref_stb | output | 1 | 32 kHz reference strobe |
| lp_stb | output | LP_W | Low prescaler tap strobes |
| cpu_clk_en | output | 1 | CPU clock enable strobe |
| pin16k_stb | output | 1 | Half-reference strobe routed to a pin |
| pincpu_stb | output | 1 | CPU clock strobe routed to a pin |

## Verification
Every cycle, the assertions check four properties. Each prescaler strobe coincides with an input tick, and the count advances by one per tick and is zero after a clear. Halt blocks the CPU enable, and a disabled crystal forces the reference onto the prescaler tap. The cold-class bits stay unchanged through a sleep reset, and the unused read bits and addresses stay zero. Other behaviours only show in the bench's directed scenarios, because they depend on long runs or on sequences of accesses: the division ratios counted over 256 and 32768 ticks, the exact crystal startup length, the write-one-to-clear timing against a running count, and the full register values after each reset class.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int REG_AW = 2;
  localparam int REG_DW = 8;

  typedef enum logic [REG_AW-1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_MISC = 2'd1,
    ADDR_PCLR = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  // control register field positions (software-visible)
  localparam int CTRL_CPUSLOW = 7;
  localparam int CTRL_EXTEN   = 5;
  localparam int CTRL_BIAS    = 4;
  localparam int CTRL_XBUSY   = 3;
  localparam int CTRL_XEN     = 1;
  localparam int CTRL_RCEN    = 0;
  // misc register field positions
  localparam int MISC_P16K    = 1;
  localparam int MISC_PCPU    = 0;
  // clear register field position
  localparam int PCLR_BIT     = 0;

  typedef struct packed {
    logic cpu_slow;
    logic ext_en;
    logic rc_bias;
    logic xtal_en;
    logic rc_en;
    logic pin16k;
    logic pincpu;
  } clk_cfg_t;
endpackage

// File: rtl/clkgen_divider.sv
module clkgen_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         clear,
  output logic [W-1:0] stb
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (tick)    cnt <= cnt + W'(1);
  end

  // tap k strobes when the low k+1 count bits are all ones on a tick
  for (genvar k = 0; k < W; k++) begin : g_tap
    assign stb[k] = tick & (&cnt[k:0]);
  end

  AST_STB_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    (|stb) |-> tick); // R2
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt == '0)); // R5
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!clear && tick) |=> (cnt == $past(cnt) + W'(1))); // R4
endmodule

// File: rtl/clkgen_xtal_start.sv
module clkgen_xtal_start #(
  parameter int START = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic xtal_en,
  input  logic xtal_tick,
  output logic busy
);
  localparam int START_C = (START < 1) ? 1 : START;
  localparam int CW      = $clog2(START_C + 1);
  localparam logic [CW-1:0] START_V = CW'(START_C);

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst || !xtal_en)             left <= START_V;
    else if (xtal_tick && left != 0) left <= left - CW'(1);
  end

  assign busy = !xtal_en || (left != '0);

  AST_BUSY_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(xtal_tick)); // R3
endmodule

// File: rtl/clkgen_regs.sv
module clkgen_regs
  import clkgen_pkg::*;
(
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              sleep_rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              xtal_busy,
  output clk_cfg_t          cfg,
  output logic              lp_clear,
  output logic [REG_DW-1:0] reg_rdata
);
  logic sleep_any;
  logic wr_ok;
  logic [REG_DW-1:0] rd_mux;
  reg_addr_e addr;

  assign sleep_any = !cold_rst_n || !sleep_rst_n;
  assign addr      = reg_addr_e'(reg_addr);
  assign wr_ok     = reg_wr && !sleep_any;

  // cold-class fields
  always_ff @(posedge clk) begin
    if (!cold_rst_n) begin
      cfg.ext_en  <= 1'b0;
      cfg.rc_bias <= 1'b1;
    end else if (wr_ok && addr == ADDR_CTRL) begin
      cfg.ext_en  <= reg_wdata[CTRL_EXTEN];
      cfg.rc_bias <= reg_wdata[CTRL_BIAS];
    end
  end

  // sleep-class fields
  always_ff @(posedge clk) begin
    if (sleep_any) begin
      cfg.cpu_slow <= 1'b0;
      cfg.xtal_en  <= 1'b0;
      cfg.rc_en    <= 1'b1;
      cfg.pin16k   <= 1'b0;
      cfg.pincpu   <= 1'b0;
    end else if (wr_ok) begin
      if (addr == ADDR_CTRL) begin
        cfg.cpu_slow <= reg_wdata[CTRL_CPUSLOW];
        cfg.xtal_en  <= reg_wdata[CTRL_XEN];
        cfg.rc_en    <= reg_wdata[CTRL_RCEN];
      end
      if (addr == ADDR_MISC) begin
        cfg.pin16k <= reg_wdata[MISC_P16K];
        cfg.pincpu <= reg_wdata[MISC_PCPU];
      end
    end
  end

  assign lp_clear = wr_ok && (addr == ADDR_PCLR) && reg_wdata[PCLR_BIT];

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_CTRL: begin
        rd_mux[CTRL_CPUSLOW] = cfg.cpu_slow;
        rd_mux[CTRL_EXTEN]   = cfg.ext_en;
        rd_mux[CTRL_BIAS]    = cfg.rc_bias;
        rd_mux[CTRL_XBUSY]   = xtal_busy;
        rd_mux[CTRL_XEN]     = cfg.xtal_en;
        rd_mux[CTRL_RCEN]    = cfg.rc_en;
      end
      ADDR_MISC: begin
        rd_mux[MISC_P16K] = cfg.pin16k;
        rd_mux[MISC_PCPU] = cfg.pincpu;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (sleep_any)   reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (sleep_any)
    (reg_rd && addr == ADDR_CTRL) |=> (reg_rdata[6] == 1'b0 && reg_rdata[2] == 1'b0)); // R10
  AST_EMPTY_ADDR_ZERO: assert property (@(posedge clk) disable iff (sleep_any)
    (reg_rd && addr == ADDR_NONE) |=> (reg_rdata == '0)); // R10
  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (sleep_any)
    (reg_rd && addr == ADDR_PCLR) |=> (reg_rdata == '0)); // R5
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (sleep_any)
    !reg_rd |=> $stable(reg_rdata)); // R10
  AST_COLD_BITS_KEEP: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !sleep_rst_n |=> ($stable(cfg.ext_en) && $stable(cfg.rc_bias))); // R9
endmodule

// File: rtl/clkgen_ctrl.sv
module clkgen_ctrl
  import clkgen_pkg::*;
#(
  parameter int HP_W       = 8,
  parameter int LP_W       = 15,
  parameter int REF_TAP    = 7,
  parameter int XTAL_START = 4
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              sleep_rst_n,
  input  logic              rc_tick,
  input  logic              ext_tick,
  input  logic              xtal_tick,
  input  logic              halt,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [7:0]        reg_rdata,
  output logic              rc_en_o,
  output logic              rc_bias_o,
  output logic              xtal_en_o,
  output logic              ext_en_o,
  output logic [HP_W-1:0]   hp_stb,
  output logic              ref_stb,
  output logic [LP_W-1:0]   lp_stb,
  output logic              cpu_clk_en,
  output logic              pin16k_stb,
  output logic              pincpu_stb
);
  clk_cfg_t cfg;
  logic     lp_clear;
  logic     xtal_busy;
  logic     cnt_rst;
  logic     src_tick;
  logic     cpu_pick;

  assign cnt_rst = !cold_rst_n || !sleep_rst_n;

  clkgen_regs u_regs (
    .clk         (clk),
    .cold_rst_n  (cold_rst_n),
    .sleep_rst_n (sleep_rst_n),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .xtal_busy   (xtal_busy),
    .cfg         (cfg),
    .lp_clear    (lp_clear),
    .reg_rdata   (reg_rdata)
  );

  clkgen_xtal_start #(.START(XTAL_START)) u_xstart (
    .clk       (clk),
    .rst       (cnt_rst),
    .xtal_en   (cfg.xtal_en),
    .xtal_tick (xtal_tick),
    .busy      (xtal_busy)
  );

  // high prescaler source: external clock wins when enabled
  assign src_tick = cfg.ext_en ? ext_tick : (cfg.rc_en & rc_tick);

  clkgen_divider #(.W(HP_W)) u_hp (
    .clk   (clk),
    .rst   (cnt_rst),
    .tick  (src_tick),
    .clear (1'b0),
    .stb   (hp_stb)
  );

  // reference: crystal once ready, else the chosen high prescaler tap
  assign ref_stb = xtal_busy ? hp_stb[REF_TAP] : xtal_tick;

  clkgen_divider #(.W(LP_W)) u_lp (
    .clk   (clk),
    .rst   (cnt_rst),
    .tick  (ref_stb),
    .clear (lp_clear),
    .stb   (lp_stb)
  );

  assign cpu_pick   = cfg.cpu_slow ? ref_stb : src_tick;
  assign cpu_clk_en = cpu_pick & ~halt;
  assign pin16k_stb = cfg.pin16k & lp_stb[0];
  assign pincpu_stb = cfg.pincpu & cpu_clk_en;

  assign rc_en_o   = cfg.rc_en;
  assign rc_bias_o = cfg.rc_bias;
  assign xtal_en_o = cfg.xtal_en;
  assign ext_en_o  = cfg.ext_en;

  AST_HALT_GATES_CPU: assert property (@(posedge clk) disable iff (cnt_rst)
    halt |-> !cpu_clk_en); // R7
  AST_REF_FALLBACK: assert property (@(posedge clk) disable iff (cnt_rst)
    !xtal_en_o |-> (ref_stb == hp_stb[REF_TAP])); // R3
  AST_PIN16K_OFF: assert property (@(posedge clk) disable iff (cnt_rst)
    !lp_stb[0] |-> !pin16k_stb); // R8
  AST_PINCPU_FOLLOWS: assert property (@(posedge clk) disable iff (cnt_rst)
    pincpu_stb |-> cpu_clk_en); // R8
endmodule

// File: tb/clkgen_ctrl_tb_top.sv
module clkgen_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       cold_rst_n, sleep_rst_n;
  logic       rc_tick, ext_tick, xtal_tick, halt;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_rdata;
  logic       rc_en_o, rc_bias_o, xtal_en_o, ext_en_o;
  logic [7:0] hp_stb;
  logic       ref_stb;
  logic [14:0] lp_stb;
  logic       cpu_clk_en, pin16k_stb, pincpu_stb;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int c_hp0, c_hp7, c_hpany, c_ref, c_lp0, c_lp1, c_lp14, c_cpu, c_p16, c_pcpu;

  clkgen_ctrl dut_i (
    .clk(clk), .cold_rst_n(cold_rst_n), .sleep_rst_n(sleep_rst_n),
    .rc_tick(rc_tick), .ext_tick(ext_tick), .xtal_tick(xtal_tick), .halt(halt),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .rc_en_o(rc_en_o), .rc_bias_o(rc_bias_o),
    .xtal_en_o(xtal_en_o), .ext_en_o(ext_en_o), .hp_stb(hp_stb), .ref_stb(ref_stb),
    .lp_stb(lp_stb), .cpu_clk_en(cpu_clk_en), .pin16k_stb(pin16k_stb),
    .pincpu_stb(pincpu_stb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic zero_counts();
    c_hp0 = 0; c_hp7 = 0; c_hpany = 0; c_ref = 0; c_lp0 = 0;
    c_lp1 = 0; c_lp14 = 0; c_cpu = 0; c_p16 = 0; c_pcpu = 0;
  endtask

  // drive ticks for n cycles, sampling combinational strobes mid-cycle
  task automatic run_ticks(input logic r, input logic e, input logic x, input int n);
    zero_counts();
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rc_tick = r; ext_tick = e; xtal_tick = x;
      #1;
      c_hp0   += int'(hp_stb[0]);
      c_hp7   += int'(hp_stb[7]);
      c_hpany += int'(|hp_stb);
      c_ref   += int'(ref_stb);
      c_lp0   += int'(lp_stb[0]);
      c_lp1   += int'(lp_stb[1]);
      c_lp14  += int'(lp_stb[14]);
      c_cpu   += int'(cpu_clk_en);
      c_p16   += int'(pin16k_stb);
      c_pcpu  += int'(pincpu_stb);
    end
    @(negedge clk);
    rc_tick = 0; ext_tick = 0; xtal_tick = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); chk("R1 ctrl after cold reset", v, 8'h19);
    rd(2'd1, v); chk("R1 misc after cold reset", v, 8'h00);
    rd(2'd2, v); chk("R1 clear reg after cold reset", v, 8'h00);
    rd(2'd3, v); chk("R1 addr3 after cold reset", v, 8'h00);
  endtask

  task automatic t_high_prescaler();
    run_ticks(1, 0, 0, 256);
    chk("R2 hp tap0 over 256 rc ticks", c_hp0, 128);
    chk("R2 hp tap7 over 256 rc ticks", c_hp7, 1);
    chk("R3 ref from tap7 with crystal off", c_ref, 1);
    run_ticks(0, 1, 0, 4);
    chk("R2 ext ticks ignored while ext disabled", c_hpany, 0);
    wr(2'd0, 8'h31);
    run_ticks(0, 1, 0, 4);
    chk("R2 hp tap0 on ext source", c_hp0, 2);
    run_ticks(1, 0, 0, 3);
    chk("R2 rc ticks ignored while ext enabled", c_hpany, 0);
    wr(2'd0, 8'h10);
    run_ticks(1, 0, 0, 4);
    chk("R2 rc ticks ignored while rc disabled", c_hpany, 0);
    wr(2'd0, 8'h11);
  endtask

  task automatic t_crystal();
    logic [7:0] v;
    wr(2'd0, 8'h13);
    rd(2'd0, v); chk("R3 busy flag after crystal enable", v, 8'h1B);
    run_ticks(0, 0, 1, 3);
    chk("R3 no reference during startup", c_ref, 0);
    rd(2'd0, v); chk("R3 still busy after 3 ticks", v, 8'h1B);
    run_ticks(0, 0, 1, 1);
    chk("R3 no reference on last startup tick", c_ref, 0);
    rd(2'd0, v); chk("R3 ready after 4 ticks", v, 8'h13);
    run_ticks(0, 0, 1, 1);
    chk("R3 reference follows crystal when ready", c_ref, 1);
  endtask

  task automatic t_low_prescaler();
    logic [7:0] v;
    wr(2'd2, 8'h01);
    rd(2'd2, v); chk("R5 clear reg reads zero", v, 8'h00);
    run_ticks(0, 0, 1, 32768);
    chk("R4 lp tap14 over 32768 refs", c_lp14, 1);
    chk("R4 lp tap0 over 32768 refs", c_lp0, 16384);
    chk("R8 pin16k off while misc bit1 clear", c_p16, 0);
    run_ticks(0, 0, 1, 3);
    wr(2'd2, 8'h01);
    run_ticks(0, 0, 1, 3);
    chk("R5 tap1 silent for 3 refs after clear", c_lp1, 0);
    run_ticks(0, 0, 1, 1);
    chk("R5 tap1 fires on 4th ref after clear", c_lp1, 1);
    run_ticks(0, 0, 1, 1);
    wr(2'd2, 8'h00);
    run_ticks(0, 0, 1, 1);
    chk("R5 writing 0 keeps count", c_lp0, 1);
  endtask

  task automatic t_cpu_select();
    wr(2'd0, 8'h93);
    run_ticks(0, 0, 1, 2);
    chk("R6 cpu follows reference when slow", c_cpu, 2);
    run_ticks(1, 0, 0, 2);
    chk("R6 rc ticks not on cpu when slow", c_cpu, 0);
    wr(2'd0, 8'h13);
    run_ticks(1, 0, 0, 3);
    chk("R6 cpu follows rc when fast", c_cpu, 3);
    run_ticks(0, 0, 1, 2);
    chk("R6 crystal not on cpu when fast", c_cpu, 0);
  endtask

  task automatic t_halt();
    @(negedge clk); halt = 1;
    run_ticks(1, 0, 0, 4);
    chk("R7 cpu enable blocked in halt", c_cpu, 0);
    @(negedge clk); halt = 0;
    run_ticks(1, 0, 0, 2);
    chk("R7 cpu enable resumes after halt", c_cpu, 2);
  endtask

  task automatic t_misc();
    logic [7:0] v;
    wr(2'd1, 8'h03);
    rd(2'd1, v); chk("R8 misc readback", v, 8'h03);
    run_ticks(1, 0, 0, 2);
    chk("R8 pincpu follows cpu enable", c_pcpu, 2);
    run_ticks(0, 0, 1, 2);
    chk("R8 pin16k over 2 refs", c_p16, 1);
    wr(2'd1, 8'h00);
    run_ticks(1, 0, 0, 2);
    chk("R8 pincpu off when bit0 clear", c_pcpu, 0);
  endtask

  task automatic t_reset_classes();
    logic [7:0] v;
    wr(2'd0, 8'hA3);
    wr(2'd1, 8'h03);
    rd(2'd0, v); chk("R9 ctrl before sleep reset", v, 8'hA3);
    @(negedge clk); sleep_rst_n = 0;
    repeat (2) @(negedge clk);
    sleep_rst_n = 1;
    rd(2'd0, v); chk("R9 ctrl after sleep reset", v, 8'h29);
    rd(2'd1, v); chk("R9 misc after sleep reset", v, 8'h00);
    @(negedge clk); cold_rst_n = 0;
    repeat (2) @(negedge clk);
    cold_rst_n = 1;
    rd(2'd0, v); chk("R9 ctrl after cold reset", v, 8'h19);
  endtask

  task automatic t_read_layout();
    logic [7:0] v;
    wr(2'd0, 8'hFF);
    rd(2'd0, v); chk("R10 ctrl unused bits and busy flag", v, 8'hBB);
    wr(2'd1, 8'h02);
    @(negedge clk);
    chk("R10 rdata holds without read", reg_rdata, 8'hBB);
    rd(2'd3, v); chk("R10 addr3 reads zero", v, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cold_rst_n = 0; sleep_rst_n = 1;
    rc_tick = 0; ext_tick = 0; xtal_tick = 0; halt = 0;
    reg_addr = 0; reg_wdata = 0; reg_wr = 0; reg_rd = 0;
    repeat (3) @(negedge clk);
    cold_rst_n = 1;
    t_reset();
    t_high_prescaler();
    t_crystal();
    t_low_prescaler();
    t_cpu_select();
    t_halt();
    t_misc();
    t_reset_classes();
    t_read_layout();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule